// File: doc/BRIEF.md
# Column Discriminator Row Serializer

This block turns the per-column binary results of one pixel row into narrow serial streams. Each row period it takes a 128-bit row word and captures it into a holding register. It then splits the word into 16 groups of 8 adjacent columns and shifts each group out on its own lane, highest column first. The lanes advance on the falling edge of a serial clock that runs at half the main clock rate.

Before the word is captured it is conditioned. A per-column disable mask forces noisy columns to zero. A programmable line pattern can stand in for the matrix data, either on every row as a digital self-test, or only on two extra rows appended to each frame. Those extra rows let downstream logic check frame alignment. A one-bit marker flags the final serial bit of the final row of each frame.

Top module: `disc_row_serializer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, all lanes and `last_bit` are 0.
- R2: Lane n carries columns n*LANE_BITS+LANE_BITS-1 down to n*LANE_BITS of the row word, so lane 0 holds columns LANE_BITS-1..0.
- R3: After a row is loaded, a lane first shows its highest-numbered column and then steps one column lower on each later serial falling edge, LANE_BITS bits per row.
- R4: Lanes and `last_bit` change only on a main-clock edge where `ser_clk` is sampled low and was high on the previous edge. At every other edge they hold their value.
- R5: On a matrix row, a `col_mask` bit of 1 forces that column to 0. A mask bit of 0 passes the discriminator bit unchanged.
- R6: With `pattern_only` high, every row takes `line_pattern` in place of `row_data`, and the mask is not applied to it.
- R7: With `marker_en` high, a frame holds ROWS_PER_FRAME matrix rows followed by MARKER_ROWS rows taken from `line_pattern`. With it low, a frame holds ROWS_PER_FRAME rows.
- R8: `last_bit` is 1 exactly while the final serial bit of the final row of a frame is on the lanes, and 0 otherwise.
- R9: The row word is captured on the clock edge where `row_sync` is high. Changes to `row_data` after that edge do not affect the row being shifted, and the captured row reaches the lanes on the first serial falling edge after capture.
- R10: A `row_sync` with `frame_sync` high makes the captured row row 0 of a new frame. After reset, and after the last row of a frame, the next row is also row 0.
- R11: When LANE_BITS bits of a row have been shifted and no new row is pending, further serial falling edges put 0 on every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Half-rate serial clock, sampled by `clk`; its falling edge advances the lanes |
| row_sync | input | 1 | One-cycle pulse that captures the current row word |
| frame_sync | input | 1 | With `row_sync`, marks the captured row as row 0 of a frame |
| row_data | input | NUM_COLS | Discriminator results of the current row, bit i = column i |
| col_mask | input | NUM_COLS | Per-column disable, 1 forces the column to 0 |
| line_pattern | input | NUM_COLS | Substitute row word for test and marker rows |
| pattern_only | input | 1 | Use `line_pattern` for every row |
| marker_en | input | 1 | Append MARKER_ROWS pattern rows to each frame |
| lane_out | output | NUM_COLS/LANE_BITS | Serial data lanes |
| last_bit | output | 1 | High during the final bit of the final row of a frame |

## Verification
The bench builds the block with 16 columns, 4 columns per lane, 3 matrix rows and 2 marker rows. At that size every column-to-lane position, every bit slot, and whole frames with and without marker rows can be compared bit by bit against a word computed in the bench. The short frame brings frame wrap-around, a mid-frame restart and the last-bit marker within reach many times in a brief run. The bench also changes `row_data` right after each capture and checks the lanes on the non-shifting edges, so the holding register and the edge qualification are both exercised.

// File: rtl/ser_pkg.sv
package ser_pkg;

  // Row conditioning mode shared by the row selector and the top.
  typedef struct packed {
    logic pattern_only;
    logic marker_en;
  } ser_mode_t;

endpackage

// File: rtl/row_select.sv
module row_select
  import ser_pkg::*;
#(
  parameter int NUM_COLS       = 128,
  parameter int ROWS_PER_FRAME = 576,
  parameter int MARKER_ROWS    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                row_sync,
  input  logic                frame_sync,
  input  logic [NUM_COLS-1:0] row_data,
  input  logic [NUM_COLS-1:0] col_mask,
  input  logic [NUM_COLS-1:0] line_pattern,
  input  ser_mode_t           mode,
  output logic [NUM_COLS-1:0] hold_word,
  output logic                hold_last
);

  localparam int MAX_ROWS = ROWS_PER_FRAME + MARKER_ROWS;
  localparam int IDX_W    = $clog2(MAX_ROWS + 1);
  localparam logic [IDX_W-1:0] IDX_MAX   = IDX_W'(MAX_ROWS - 1);
  localparam logic [IDX_W-1:0] IDX_PLAIN = IDX_W'(ROWS_PER_FRAME - 1);
  localparam logic [IDX_W-1:0] IDX_FIRST_MK = IDX_W'(ROWS_PER_FRAME);

  logic [IDX_W-1:0]    row_idx;
  logic [IDX_W-1:0]    idx_next;
  logic [IDX_W-1:0]    last_idx;
  logic                is_marker;
  logic [NUM_COLS-1:0] sel_word;

  always_comb begin
    last_idx = mode.marker_en ? IDX_MAX : IDX_PLAIN;
    if (frame_sync || (row_idx >= last_idx)) begin
      idx_next = '0;
    end else begin
      idx_next = row_idx + 1'b1;
    end
  end

  generate
    if (MARKER_ROWS > 0) begin : g_marker
      assign is_marker = mode.marker_en && (idx_next >= IDX_FIRST_MK);
    end else begin : g_no_marker
      assign is_marker = 1'b0;
    end
  endgenerate

  // Pattern rows bypass the column mask; matrix rows are gated by it.
  always_comb begin
    if (mode.pattern_only || is_marker) begin
      sel_word = line_pattern;
    end else begin
      sel_word = row_data & ~col_mask;
    end
  end

  // Reset index sits on the largest row so the first capture becomes row 0.
  always_ff @(posedge clk) begin
    if (rst) begin
      row_idx   <= IDX_MAX;
      hold_word <= '0;
      hold_last <= 1'b0;
    end else if (row_sync) begin
      row_idx   <= idx_next;
      hold_word <= sel_word;
      hold_last <= (idx_next == last_idx);
    end
  end

endmodule

// File: rtl/bit_timer.sv
module bit_timer #(
  parameter int LANE_BITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_clk,
  input  logic row_sync,
  input  logic hold_last,
  output logic load_en,
  output logic shift_en,
  output logic last_bit
);

  localparam int CNT_W = $clog2(LANE_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_IDLE = CNT_W'(LANE_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LANE_BITS - 1);

  logic             ser_q;
  logic             fall_ev;
  logic             pending;
  logic             row_last;
  logic [CNT_W-1:0] bit_cnt;
  logic [CNT_W-1:0] cnt_inc;

  assign fall_ev  = ser_q & ~ser_clk;
  assign load_en  = fall_ev & pending;
  assign shift_en = fall_ev & ~pending;
  assign cnt_inc  = bit_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_q   <= 1'b0;
      pending <= 1'b0;
    end else begin
      ser_q <= ser_clk;
      if (row_sync) begin
        pending <= 1'b1;
      end else if (fall_ev) begin
        pending <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= CNT_IDLE;
      row_last <= 1'b0;
      last_bit <= 1'b0;
    end else if (load_en) begin
      bit_cnt  <= '0;
      row_last <= hold_last;
      last_bit <= (LANE_BITS == 1) && hold_last;
    end else if (shift_en) begin
      if (bit_cnt != CNT_IDLE) begin
        bit_cnt  <= cnt_inc;
        last_bit <= row_last && (cnt_inc == CNT_LAST);
      end else begin
        last_bit <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/lane_shifter.sv
module lane_shifter #(
  parameter int LANE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load_en,
  input  logic                 shift_en,
  input  logic [LANE_BITS-1:0] load_bits,
  output logic                 ser_out
);

  logic [LANE_BITS-1:0] sh;

  // Highest column leaves first; zeros fill in behind.
  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0;
    end else if (load_en) begin
      sh <= load_bits;
    end else if (shift_en) begin
      sh <= sh << 1;
    end
  end

  assign ser_out = sh[LANE_BITS-1];

endmodule

// File: rtl/disc_row_serializer.sv
module disc_row_serializer
  import ser_pkg::*;
#(
  parameter int NUM_COLS       = 128,
  parameter int LANE_BITS      = 8,
  parameter int ROWS_PER_FRAME = 576,
  parameter int MARKER_ROWS    = 2,
  localparam int NUM_LANES     = NUM_COLS / LANE_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ser_clk,
  input  logic                 row_sync,
  input  logic                 frame_sync,
  input  logic [NUM_COLS-1:0]  row_data,
  input  logic [NUM_COLS-1:0]  col_mask,
  input  logic [NUM_COLS-1:0]  line_pattern,
  input  logic                 pattern_only,
  input  logic                 marker_en,
  output logic [NUM_LANES-1:0] lane_out,
  output logic                 last_bit
);

  ser_mode_t           mode;
  logic [NUM_COLS-1:0] hold_word;
  logic                hold_last;
  logic                load_en;
  logic                shift_en;

  assign mode.pattern_only = pattern_only;
  assign mode.marker_en    = marker_en;

  row_select #(
    .NUM_COLS       (NUM_COLS),
    .ROWS_PER_FRAME (ROWS_PER_FRAME),
    .MARKER_ROWS    (MARKER_ROWS)
  ) u_sel (
    .clk          (clk),
    .rst          (rst),
    .row_sync     (row_sync),
    .frame_sync   (frame_sync),
    .row_data     (row_data),
    .col_mask     (col_mask),
    .line_pattern (line_pattern),
    .mode         (mode),
    .hold_word    (hold_word),
    .hold_last    (hold_last)
  );

  bit_timer #(
    .LANE_BITS (LANE_BITS)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .ser_clk   (ser_clk),
    .row_sync  (row_sync),
    .hold_last (hold_last),
    .load_en   (load_en),
    .shift_en  (shift_en),
    .last_bit  (last_bit)
  );

  generate
    for (genvar n = 0; n < NUM_LANES; n++) begin : g_lane
      lane_shifter #(
        .LANE_BITS (LANE_BITS)
      ) u_lane (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .shift_en  (shift_en),
        .load_bits (hold_word[n*LANE_BITS +: LANE_BITS]),
        .ser_out   (lane_out[n])
      );
    end
  endgenerate

endmodule

// File: rtl/serializer_chk.sv
module serializer_chk #(
  parameter int NUM_COLS  = 128,
  parameter int NUM_LANES = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ser_clk,
  input logic                 row_sync,
  input logic                 pattern_only,
  input logic                 marker_en,
  input logic [NUM_COLS-1:0]  col_mask,
  input logic [NUM_COLS-1:0]  line_pattern,
  input logic [NUM_LANES-1:0] lane_out,
  input logic                 last_bit,
  input logic [NUM_COLS-1:0]  hold_word
);

  logic ser_prev;
  logic ev_c;

  always_ff @(posedge clk) begin
    if (rst) ser_prev <= 1'b0;
    else     ser_prev <= ser_clk;
  end

  assign ev_c = ser_prev & ~ser_clk;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (lane_out == '0) && !last_bit);

  // R4
  lanes_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ev_c |=> $stable(lane_out));

  // R5
  mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (row_sync && !pattern_only && !marker_en) |=> ((hold_word & $past(col_mask)) == '0));

  // R6
  pattern_take_chk: assert property (@(posedge clk) disable iff (rst)
    (row_sync && pattern_only) |=> (hold_word == $past(line_pattern)));

  // R8
  last_rise_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(last_bit) |-> $past(ev_c));

  // R8
  last_held_chk: assert property (@(posedge clk) disable iff (rst)
    (last_bit && !ev_c) |=> last_bit);

endmodule

bind disc_row_serializer serializer_chk #(
  .NUM_COLS  (NUM_COLS),
  .NUM_LANES (NUM_LANES)
) i_chk (
  .clk          (clk),
  .rst          (rst),
  .ser_clk      (ser_clk),
  .row_sync     (row_sync),
  .pattern_only (pattern_only),
  .marker_en    (marker_en),
  .col_mask     (col_mask),
  .line_pattern (line_pattern),
  .lane_out     (lane_out),
  .last_bit     (last_bit),
  .hold_word    (hold_word)
);

// File: tb/test_disc_row_serializer.sv
module test_disc_row_serializer;

  localparam int CLK_PERIOD = 10;
  localparam int NC    = 16;
  localparam int LB    = 4;
  localparam int NL    = NC / LB;
  localparam int ROWS  = 3;
  localparam int MROWS = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ser_clk = 1'b0;
  logic          row_sync = 1'b0;
  logic          frame_sync = 1'b0;
  logic [NC-1:0] row_data = '0;
  logic [NC-1:0] col_mask = '0;
  logic [NC-1:0] line_pattern = '0;
  logic          pattern_only = 1'b0;
  logic          marker_en = 1'b0;
  logic [NL-1:0] lane_out;
  logic          last_bit;

  int checks = 0;
  int fails  = 0;
  int bidx   = ROWS + MROWS - 1;
  logic [NL-1:0] last_seen = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disc_row_serializer #(
    .NUM_COLS       (NC),
    .LANE_BITS      (LB),
    .ROWS_PER_FRAME (ROWS),
    .MARKER_ROWS    (MROWS)
  ) i_disc_row_serializer (
    .clk          (clk),
    .rst          (rst),
    .ser_clk      (ser_clk),
    .row_sync     (row_sync),
    .frame_sync   (frame_sync),
    .row_data     (row_data),
    .col_mask     (col_mask),
    .line_pattern (line_pattern),
    .pattern_only (pattern_only),
    .marker_en    (marker_en),
    .lane_out     (lane_out),
    .last_bit     (last_bit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [NL-1:0] lane_bits(input logic [NC-1:0] w, input int b);
    logic [NL-1:0] v;
    for (int n = 0; n < NL; n++) v[n] = w[n*LB + LB - 1 - b];
    return v;
  endfunction

  // One serial period; the non-shifting edge is checked for stability (R4).
  task automatic serial_bit();
    @(negedge clk) ser_clk = 1'b1;
    @(posedge clk) #1;
    chk("R4", 32'(lane_out), 32'(last_seen));
    @(negedge clk) ser_clk = 1'b0;
    @(posedge clk) #1;
    last_seen = lane_out;
  endtask

  task automatic do_row(input logic [NC-1:0] data, input logic fsync, input string tag);
    int last_i;
    int nidx;
    logic [NC-1:0] expw;
    logic exp_last;
    last_i = marker_en ? ROWS + MROWS - 1 : ROWS - 1;
    nidx = (fsync || bidx >= last_i) ? 0 : bidx + 1;
    bidx = nidx;
    if (pattern_only || (marker_en && nidx >= ROWS)) expw = line_pattern;
    else expw = data & ~col_mask;
    exp_last = (nidx == last_i);
    @(negedge clk);
    row_data = data; frame_sync = fsync; row_sync = 1'b1;
    @(negedge clk);
    row_sync = 1'b0; frame_sync = 1'b0;
    row_data = ~data; // R9: post-capture change must not leak into the row
    for (int b = 0; b < LB; b++) begin
      serial_bit();
      chk(tag, 32'(lane_out), 32'(lane_bits(expw, b)));
      chk("R8", 32'(last_bit), 32'(exp_last && (b == LB - 1)));
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk("R1", 32'(lane_out), 0);
    chk("R1", 32'(last_bit), 0);
    @(negedge clk) rst = 1'b0;
    @(posedge clk) #1;
    chk("R1", 32'(lane_out), 0);

    // R2 and R10: first frame after reset, lane mapping
    for (int r = 0; r < ROWS; r++) do_row(NC'(16'h1234 * (r + 1)) ^ 16'hA5A5, r == 0, "R2");
    // R3 and R10: frame wraps without a frame_sync
    for (int r = 0; r < ROWS; r++) do_row(NC'(16'h8001 << r) | NC'(16'h0F00 >> r), 1'b0, "R3");
    do_row(16'hFFFF, 1'b0, "R9");

    // R5: masked columns forced low
    col_mask = 16'hF00F;
    for (int r = 0; r < ROWS; r++) do_row(16'hFFFF ^ NC'(r * 16'h1111), r == 0, "R5");
    col_mask = 16'h0FF0;
    do_row(16'hFFFF, 1'b1, "R5");

    // R6: pattern replaces data and ignores the mask
    col_mask = 16'hFFFF;
    pattern_only = 1'b1;
    line_pattern = 16'hC3A5;
    for (int r = 0; r < ROWS; r++) do_row(NC'(16'h3C3C + r), r == 0, "R6");
    pattern_only = 1'b0;
    col_mask = '0;

    // R7: marker rows appended, frame of ROWS+MROWS rows, then wrap to row 0
    marker_en = 1'b1;
    line_pattern = 16'h5AF0;
    for (int r = 0; r < ROWS + MROWS; r++) do_row(NC'(16'h0101 * (r + 3)), r == 0, "R7");
    do_row(16'h7E81, 1'b0, "R7");

    // R10: restart mid-frame
    do_row(16'h1111, 1'b0, "R10");
    for (int r = 0; r < ROWS + MROWS; r++) do_row(NC'(16'hB00D) ^ NC'(r), r == 0, "R10");
    marker_en = 1'b0;

    // R11: no new row pending, lanes drain to zero
    for (int b = 0; b < 2; b++) begin
      serial_bit();
      chk("R11", 32'(lane_out), 0);
      chk("R11", 32'(last_bit), 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule